// File: doc/BRIEF.md
# Flash Page Relocation Manager

This block fronts a small model of a flash array whose storage is cut into erase blocks of `PPB` pages. A client issues whole-page read and write requests by logical page number. A page can be programmed only while it is still in the erased state. When the target page is still erased, a write programs it in place. When the target page already holds data, the block runs a relocation. It picks a spare physical block, erases it over a long multi-cycle latency and programs the new page there. It then copies across every other programmed page of the old block, repoints the logical block at the new physical block and releases the old one.

Each physical block keeps an erase counter. A block whose counter has reached the wear limit is never chosen again. If no usable spare exists, the write fails with an error flag and the stored data stay as they were. While a relocation is running, `busy` is high and any request on the input is held off until it drops. Every accepted request produces exactly one response pulse.

Top module: `flash_reloc_mgr`

## Requirements
- R1: After reset `busy` and `rsp_valid` are low, and every logical page reads back as all ones.
- R2: A read is accepted when `req_valid` is high and `busy` is low. Its response (`rsp_valid`=1, `rsp_err`=0) comes in the next cycle. If the page has not been programmed since its block was last erased, `rsp_rdata` is all ones.
- R3: A write to an erased page programs it in place. The response comes in the next cycle with `rsp_err`=0, and `busy` stays low.
- R4: A read of a programmed page returns the data most recently written to that logical page.
- R5: A write to a programmed page starts a relocation. `busy` goes high in the cycle after acceptance and stays high for exactly `ERASE_CYC + PPB + 2` cycles. The response (`rsp_err`=0) arrives in the first cycle after `busy` falls.
- R6: After a relocation, the other programmed pages of the logical block read back unchanged. Pages that were erased still read as all ones and can then be written without a relocation.
- R7: While `busy` is high no request is accepted and no response is given. A request held on the input is accepted once `busy` is low.
- R8: The logical page number is split into a logical block (upper bits) and a page index (low `log2(PPB)` bits). After reset, logical block n maps to physical block n and physical blocks `NLOG`..`NPHYS-1` are spare. A relocation takes the lowest-numbered spare block whose erase count is below `WEAR_LIMIT`, and the old block becomes spare.
- R9: Each erase adds one to the erase count of that physical block. A block whose count equals `WEAR_LIMIT` is never chosen again.
- R10: If a relocation finds no eligible spare block, the response comes in the next cycle with `rsp_err`=1, `busy` stays low, and all stored data and the mapping are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_write | input | 1 | 1 = page write, 0 = page read |
| req_lpage | input | log2(NLOG)+log2(PPB) | Logical page: block in upper bits, page index in low bits |
| req_wdata | input | DW | Page data for a write |
| busy | output | 1 | Relocation in progress; requests are stalled |
| rsp_valid | output | 1 | One-cycle response pulse for each accepted request |
| rsp_err | output | 1 | Write could not be placed (no eligible spare block) |
| rsp_rdata | output | DW | Read data; zero on write responses |

## Verification
Reads of untouched pages, first writes to erased pages and rewrites of programmed pages are interleaved, so in-place programming and relocation are told apart by the length of the `busy` window. After a rewrite, reads of neighbouring programmed and unprogrammed pages show whether the copy kept valid pages and left erased ones alone. A request issued right behind a relocation shows the stall. A long run of rewrites to one logical block then cycles the spares until every candidate reaches the wear limit. This checks the lowest-index allocation order, the wear cut-off and the error path that keeps old data.

// File: rtl/fprm_pkg.sv
// Shared types for the flash page relocation manager.
package fprm_pkg;
    // Sequencer states: idle, erasing a spare, programming the new page,
    // copying surviving pages, committing the remap.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_PROG,
        ST_COPY,
        ST_DONE
    } fprm_state_e;
endpackage

// File: rtl/fprm_page_store.sv
// Page store: models the flash array as NBLK blocks of PPB pages, each page
// with a programmed flag. Assumes the sequencer never programs a page whose
// flag is set and never erases and programs the same block in one cycle.
// An unprogrammed page reads as all ones.
module fprm_page_store #(
    parameter int NBLK = 6,
    parameter int PPB  = 32,
    parameter int DW   = 32,
    localparam int PB_W = $clog2(NBLK),
    localparam int PG_W = $clog2(PPB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PB_W-1:0] wr_blk,
    input  logic [PG_W-1:0] wr_pg,
    input  logic [DW-1:0]   wr_data,
    input  logic            er_en,
    input  logic [PB_W-1:0] er_blk,
    input  logic [PB_W-1:0] rd_blk,
    input  logic [PG_W-1:0] rd_pg,
    output logic [DW-1:0]   rd_data,
    output logic            rd_prog
);
    logic [DW-1:0]                mem_q [NBLK][PPB];
    logic [NBLK-1:0][PPB-1:0]     prog_q;

    // Page contents: written on program, no reset (array contents).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_blk][wr_pg] <= wr_data;
        end
    end

    // Programmed flags: cleared by reset or block erase, set by program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= '0;
        end else begin
            if (er_en) begin
                prog_q[er_blk] <= '0;
            end
            if (wr_en) begin
                prog_q[wr_blk][wr_pg] <= 1'b1;
            end
        end
    end

    // Read path: erased pages return all ones.
    always_comb begin
        rd_prog = prog_q[rd_blk][rd_pg];
        rd_data = rd_prog ? mem_q[rd_blk][rd_pg] : '1;
    end

    // R3: a page is only programmed while it is in the erased state.
    a_r3_prog_only_erased: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !prog_q[wr_blk][wr_pg]);

    // R5: an erase never collides with a program of the same block.
    a_r5_erase_prog_apart: assert property (@(posedge clk) disable iff (!rst_n)
        er_en |-> !(wr_en && (wr_blk == er_blk)));
endmodule

// File: rtl/fprm_block_pool.sv
// Block pool: logical-to-physical map, spare flags and per-block erase
// counters. Offers the lowest-numbered spare below the wear limit. Assumes
// commit names a spare as the new block and the mapped block as the old one.
module fprm_block_pool #(
    parameter int NLOG       = 4,
    parameter int NPHYS      = 6,
    parameter int WEAR_LIMIT = 100000,
    localparam int LB_W = $clog2(NLOG),
    localparam int PB_W = $clog2(NPHYS),
    localparam int WC_W = $clog2(WEAR_LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LB_W-1:0] lk_lblk,
    output logic [PB_W-1:0] lk_pblk,
    output logic            alloc_ok,
    output logic [PB_W-1:0] alloc_blk,
    input  logic            inc_en,
    input  logic [PB_W-1:0] inc_blk,
    input  logic            commit_en,
    input  logic [LB_W-1:0] commit_lblk,
    input  logic [PB_W-1:0] commit_new,
    input  logic [PB_W-1:0] commit_old
);
    localparam logic [WC_W-1:0] WL = WC_W'(WEAR_LIMIT);

    logic [PB_W-1:0]              map_q [NLOG];
    logic [NPHYS-1:0][WC_W-1:0]   cnt_v;
    logic [NPHYS-1:0]             free_v;
    logic [NPHYS-1:0]             elig_v;

    // Mapping table: identity after reset, updated on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NLOG; l++) begin
                map_q[l] <= PB_W'(l);
            end
        end else if (commit_en) begin
            map_q[commit_lblk] <= commit_new;
        end
    end

    assign lk_pblk = map_q[lk_lblk];

    // Per-block state: erase counter and spare flag.
    for (genvar gb = 0; gb < NPHYS; gb++) begin : g_blk
        logic [WC_W-1:0] cnt_r;
        logic            free_r;

        // Counter counts erases; spare flag follows commits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_r  <= '0;
                free_r <= (gb >= NLOG);
            end else begin
                if (inc_en && (inc_blk == PB_W'(gb))) begin
                    cnt_r <= cnt_r + 1'b1;
                end
                if (commit_en && (commit_new == PB_W'(gb))) begin
                    free_r <= 1'b0;
                end else if (commit_en && (commit_old == PB_W'(gb))) begin
                    free_r <= 1'b1;
                end
            end
        end

        assign cnt_v[gb]  = cnt_r;
        assign free_v[gb] = free_r;
        assign elig_v[gb] = free_r && (cnt_r < WL);
    end

    // Allocator: lowest-numbered eligible spare wins.
    always_comb begin
        alloc_ok  = |elig_v;
        alloc_blk = '0;
        for (int b = NPHYS - 1; b >= 0; b--) begin
            if (elig_v[b]) begin
                alloc_blk = PB_W'(b);
            end
        end
    end

    // R8: a commit moves a spare into use and releases a block that was in use.
    a_r8_commit_spare: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (free_v[commit_new] && !free_v[commit_old]));

    // R9: a worn block is never erased again.
    a_r9_erase_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en |-> (cnt_v[inc_blk] < WL));
endmodule

// File: rtl/fprm_ctrl.sv
// Sequencer: accepts page requests when idle. It serves reads and first writes
// in one cycle and runs erase, program, copy and commit for rewrites. Assumes
// ERASE_CYC >= 1 and that the pool and store answer combinationally.
module fprm_ctrl
    import fprm_pkg::*;
#(
    parameter int NLOG      = 4,
    parameter int NPHYS     = 6,
    parameter int PPB       = 32,
    parameter int DW        = 32,
    parameter int ERASE_CYC = 1000,
    localparam int LB_W = $clog2(NLOG),
    localparam int PB_W = $clog2(NPHYS),
    localparam int PG_W = $clog2(PPB),
    localparam int LP_W = LB_W + PG_W,
    localparam int EC_W = $clog2(ERASE_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [LP_W-1:0] req_lpage,
    input  logic [DW-1:0]   req_wdata,
    output logic            busy,
    output logic            rsp_valid,
    output logic            rsp_err,
    output logic [DW-1:0]   rsp_rdata,
    output logic            wr_en,
    output logic [PB_W-1:0] wr_blk,
    output logic [PG_W-1:0] wr_pg,
    output logic [DW-1:0]   wr_data,
    output logic            er_en,
    output logic [PB_W-1:0] er_blk,
    output logic [PB_W-1:0] rd_blk,
    output logic [PG_W-1:0] rd_pg,
    input  logic [DW-1:0]   rd_data,
    input  logic            rd_prog,
    output logic [LB_W-1:0] lk_lblk,
    input  logic [PB_W-1:0] lk_pblk,
    input  logic            alloc_ok,
    input  logic [PB_W-1:0] alloc_blk,
    output logic            inc_en,
    output logic [PB_W-1:0] inc_blk,
    output logic            commit_en,
    output logic [LB_W-1:0] commit_lblk,
    output logic [PB_W-1:0] commit_new,
    output logic [PB_W-1:0] commit_old
);
    fprm_state_e       state_q;
    logic [EC_W-1:0]   ecnt_q;
    logic [PB_W-1:0]   new_q;
    logic [PB_W-1:0]   old_q;
    logic [LB_W-1:0]   lblk_q;
    logic [PG_W-1:0]   pg_q;
    logic [PG_W-1:0]   idx_q;
    logic [DW-1:0]     wdata_q;
    logic [LB_W-1:0]   req_lblk;
    logic [PG_W-1:0]   req_pg;
    logic              accept;

    assign req_lblk = req_lpage[LP_W-1:PG_W];
    assign req_pg   = req_lpage[PG_W-1:0];
    assign accept   = req_valid && (state_q == ST_IDLE);
    assign busy     = (state_q != ST_IDLE);

    // Address steering: request address when idle, old block during copy.
    always_comb begin
        lk_lblk = (state_q == ST_IDLE) ? req_lblk : lblk_q;
        rd_blk  = (state_q == ST_COPY) ? old_q : lk_pblk;
        rd_pg   = (state_q == ST_COPY) ? idx_q : req_pg;
    end

    // Program port: in-place write, new page, or copy of a surviving page.
    always_comb begin
        wr_en   = 1'b0;
        wr_blk  = new_q;
        wr_pg   = pg_q;
        wr_data = wdata_q;
        case (state_q)
            ST_IDLE: begin
                if (accept && req_write && !rd_prog) begin
                    wr_en   = 1'b1;
                    wr_blk  = lk_pblk;
                    wr_pg   = req_pg;
                    wr_data = req_wdata;
                end
            end
            ST_PROG: wr_en = 1'b1;
            ST_COPY: begin
                if ((idx_q != pg_q) && rd_prog) begin
                    wr_en   = 1'b1;
                    wr_pg   = idx_q;
                    wr_data = rd_data;
                end
            end
            default: ;
        endcase
    end

    // Erase strobe and wear count at the end of the erase wait; remap at commit.
    always_comb begin
        er_en       = (state_q == ST_ERASE) && (ecnt_q == '0);
        er_blk      = new_q;
        inc_en      = er_en;
        inc_blk     = new_q;
        commit_en   = (state_q == ST_DONE);
        commit_lblk = lblk_q;
        commit_new  = new_q;
        commit_old  = old_q;
    end

    // Sequencer state, captured request and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ecnt_q    <= '0;
            new_q     <= '0;
            old_q     <= '0;
            lblk_q    <= '0;
            pg_q      <= '0;
            idx_q     <= '0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        rsp_err   <= 1'b0;
                        rsp_rdata <= '0;
                        if (!req_write) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= rd_data;
                        end else if (!rd_prog) begin
                            rsp_valid <= 1'b1;
                        end else if (!alloc_ok) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                        end else begin
                            state_q <= ST_ERASE;
                            ecnt_q  <= EC_W'(ERASE_CYC - 1);
                            new_q   <= alloc_blk;
                            old_q   <= lk_pblk;
                            lblk_q  <= req_lblk;
                            pg_q    <= req_pg;
                            wdata_q <= req_wdata;
                        end
                    end
                end
                ST_ERASE: begin
                    if (ecnt_q == '0) begin
                        state_q <= ST_PROG;
                    end else begin
                        ecnt_q <= ecnt_q - 1'b1;
                    end
                end
                ST_PROG: begin
                    state_q <= ST_COPY;
                    idx_q   <= '0;
                end
                ST_COPY: begin
                    if (idx_q == PG_W'(PPB - 1)) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    state_q   <= ST_IDLE;
                    rsp_valid <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: no response is given while a relocation holds the block busy.
    a_r7_no_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rsp_valid);

    // R5: the new page is programmed only straight after the erase wait.
    a_r5_prog_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> ($past(state_q) == ST_ERASE));

    // R10: an error response answers a write accepted in the cycle before.
    a_r10_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> $past(accept && req_write));
endmodule

// File: rtl/flash_reloc_mgr.sv
// Top level: page requests in, one response per request out. The page store
// models the array. The block pool holds mapping and wear state. The
// sequencer runs in-place writes and erase-copy-remap relocations.
// Assumes NLOG and PPB are powers of two and NPHYS > NLOG.
module flash_reloc_mgr #(
    parameter int NLOG       = 4,
    parameter int NPHYS      = 6,
    parameter int PPB        = 32,
    parameter int DW         = 32,
    parameter int ERASE_CYC  = 1000,
    parameter int WEAR_LIMIT = 100000,
    localparam int LP_W = $clog2(NLOG) + $clog2(PPB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [LP_W-1:0] req_lpage,
    input  logic [DW-1:0]   req_wdata,
    output logic            busy,
    output logic            rsp_valid,
    output logic            rsp_err,
    output logic [DW-1:0]   rsp_rdata
);
    localparam int LB_W = $clog2(NLOG);
    localparam int PB_W = $clog2(NPHYS);
    localparam int PG_W = $clog2(PPB);

    logic            wr_en;
    logic [PB_W-1:0] wr_blk;
    logic [PG_W-1:0] wr_pg;
    logic [DW-1:0]   wr_data;
    logic            er_en;
    logic [PB_W-1:0] er_blk;
    logic [PB_W-1:0] rd_blk;
    logic [PG_W-1:0] rd_pg;
    logic [DW-1:0]   rd_data;
    logic            rd_prog;
    logic [LB_W-1:0] lk_lblk;
    logic [PB_W-1:0] lk_pblk;
    logic            alloc_ok;
    logic [PB_W-1:0] alloc_blk;
    logic            inc_en;
    logic [PB_W-1:0] inc_blk;
    logic            commit_en;
    logic [LB_W-1:0] commit_lblk;
    logic [PB_W-1:0] commit_new;
    logic [PB_W-1:0] commit_old;

    fprm_ctrl #(
        .NLOG(NLOG), .NPHYS(NPHYS), .PPB(PPB), .DW(DW), .ERASE_CYC(ERASE_CYC)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_lpage(req_lpage), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .wr_en(wr_en), .wr_blk(wr_blk), .wr_pg(wr_pg), .wr_data(wr_data),
        .er_en(er_en), .er_blk(er_blk),
        .rd_blk(rd_blk), .rd_pg(rd_pg), .rd_data(rd_data), .rd_prog(rd_prog),
        .lk_lblk(lk_lblk), .lk_pblk(lk_pblk),
        .alloc_ok(alloc_ok), .alloc_blk(alloc_blk),
        .inc_en(inc_en), .inc_blk(inc_blk),
        .commit_en(commit_en), .commit_lblk(commit_lblk),
        .commit_new(commit_new), .commit_old(commit_old)
    );

    fprm_page_store #(
        .NBLK(NPHYS), .PPB(PPB), .DW(DW)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_blk(wr_blk), .wr_pg(wr_pg), .wr_data(wr_data),
        .er_en(er_en), .er_blk(er_blk),
        .rd_blk(rd_blk), .rd_pg(rd_pg), .rd_data(rd_data), .rd_prog(rd_prog)
    );

    fprm_block_pool #(
        .NLOG(NLOG), .NPHYS(NPHYS), .WEAR_LIMIT(WEAR_LIMIT)
    ) pool_i (
        .clk(clk), .rst_n(rst_n),
        .lk_lblk(lk_lblk), .lk_pblk(lk_pblk),
        .alloc_ok(alloc_ok), .alloc_blk(alloc_blk),
        .inc_en(inc_en), .inc_blk(inc_blk),
        .commit_en(commit_en), .commit_lblk(commit_lblk),
        .commit_new(commit_new), .commit_old(commit_old)
    );
endmodule

// File: tb/flash_reloc_mgr_tb_top.sv
// Scoreboard bench: the driver task predicts each response from a
// requirement-level model and queues it; the monitor compares at negedges.
module flash_reloc_mgr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NLOG       = 2;
    localparam int NPHYS      = 3;
    localparam int PPB        = 4;
    localparam int DW         = 8;
    localparam int ERASE_CYC  = 10;
    localparam int WEAR_LIMIT = 3;
    localparam int LP_W       = 3;
    localparam int NLP        = NLOG * PPB;
    localparam int RELOC_BUSY = ERASE_CYC + PPB + 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic            req_write;
    logic [LP_W-1:0] req_lpage;
    logic [DW-1:0]   req_wdata;
    logic            busy;
    logic            rsp_valid;
    logic            rsp_err;
    logic [DW-1:0]   rsp_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_reloc_mgr #(
        .NLOG(NLOG), .NPHYS(NPHYS), .PPB(PPB), .DW(DW),
        .ERASE_CYC(ERASE_CYC), .WEAR_LIMIT(WEAR_LIMIT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_lpage(req_lpage), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic          err;
        logic [DW-1:0] data;
        logic          chk_data;
        logic [15:0]   busy_len;
    } exp_t;

    exp_t    exp_q[$];
    string   tag_q[$];
    exp_t    cur;
    string   cur_tag;
    int      checks   = 0;
    int      errors   = 0;
    int      busy_run = 0;
    bit      finished = 0;

    logic [DW-1:0] mdat [NLP];
    bit            mprg [NLP];
    int            bmap [NLOG];
    bit            bfree [NPHYS];
    int            bcnt [NPHYS];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Monitor: count busy cycles, pop and compare on each response.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy) busy_run++;
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected response", 1, 0);
                end else begin
                    cur     = exp_q.pop_front();
                    cur_tag = tag_q.pop_front();
                    check(rsp_err == cur.err, cur_tag, "error flag", rsp_err, cur.err);
                    if (cur.chk_data)
                        check(rsp_rdata == cur.data, cur_tag, "read data", rsp_rdata, cur.data);
                    check(busy_run == int'(cur.busy_len), cur_tag, "busy cycles",
                          busy_run, cur.busy_len);
                end
                busy_run = 0;
            end
        end
    end

    // Driver: predict the response, queue it, then hold the request until accepted.
    task automatic issue(input bit wr, input int lp, input logic [DW-1:0] d, input string tag);
        exp_t e;
        int   lb;
        int   nb;
        bit   acc;
        e  = '0;
        lb = lp / PPB;
        if (!wr) begin
            e.chk_data = 1'b1;
            e.data     = mprg[lp] ? mdat[lp] : '1;
        end else if (!mprg[lp]) begin
            mprg[lp] = 1'b1;
            mdat[lp] = d;
        end else begin
            nb = -1;
            for (int b = NPHYS - 1; b >= 0; b--)
                if (bfree[b] && bcnt[b] < WEAR_LIMIT) nb = b;
            if (nb < 0) begin
                e.err = 1'b1;
            end else begin
                bcnt[nb]++;
                bfree[nb]       = 1'b0;
                bfree[bmap[lb]] = 1'b1;
                bmap[lb]        = nb;
                mdat[lp]        = d;
                e.busy_len      = 16'(RELOC_BUSY);
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_lpage = LP_W'(lp);
        req_wdata = d;
        do begin
            acc = !busy;
            @(negedge clk);
        end while (!acc);
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        for (int p = 0; p < NLP; p++) begin
            mprg[p] = 1'b0;
            mdat[p] = '0;
        end
        for (int l = 0; l < NLOG; l++) bmap[l] = l;
        for (int b = 0; b < NPHYS; b++) begin
            bfree[b] = (b >= NLOG);
            bcnt[b]  = 0;
        end
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_lpage = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        // R1: every page erased after reset
        for (int p = 0; p < NLP; p++) issue(1'b0, p, '0, "R1");
        // R3: first writes program in place
        issue(1'b1, 0, 8'h11, "R3");
        issue(1'b1, 1, 8'h22, "R3");
        issue(1'b1, 2, 8'h33, "R3");
        issue(1'b1, 5, 8'h55, "R3");
        // R4: read back; R2: unwritten page still ones
        issue(1'b0, 0, '0, "R4");
        issue(1'b0, 1, '0, "R4");
        issue(1'b0, 5, '0, "R4");
        issue(1'b0, 3, '0, "R2");
        // R5: rewrite relocates; R7: next request stalls behind it
        issue(1'b1, 1, 8'hA2, "R5");
        issue(1'b0, 1, '0, "R7");
        // R6: neighbours survive the copy, erased page stays erased
        issue(1'b0, 0, '0, "R6");
        issue(1'b0, 2, '0, "R6");
        issue(1'b0, 3, '0, "R6");
        issue(1'b1, 3, 8'h44, "R6");
        issue(1'b0, 3, '0, "R6");
        // R5: relocation of the second logical block
        issue(1'b1, 5, 8'h5A, "R5");
        issue(1'b0, 4, '0, "R6");
        issue(1'b0, 5, '0, "R4");
        // R8 then R9: repeated rewrites cycle the spares until worn out
        for (int i = 0; i < 10; i++) begin
            issue(1'b1, 0, DW'(8'h80 + i), (i < 3) ? "R8" : "R9");
            issue(1'b0, 0, '0, (i < 3) ? "R8" : "R9");
        end
        // R10: no eligible spare, error and data kept
        issue(1'b1, 5, 8'hEE, "R10");
        issue(1'b0, 5, '0, "R10");
        issue(1'b1, 2, 8'hEF, "R10");
        issue(1'b0, 2, '0, "R10");
        issue(1'b0, 1, '0, "R10");
        for (int w = 0; w < 100 && exp_q.size() > 0; w++) @(negedge clk);
        check(exp_q.size() == 0, "R7", "responses outstanding", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end
endmodule